// File: doc/BRIEF.md
# Unified Address Translation Lookaside Buffer with Access Protection

This block turns a 32-bit virtual address into a 29-bit physical address. It looks the address up in a small, fully associative table of translation entries held in registers, and each entry may describe a 1 KB, 4 KB, 64 KB or 1 MB page. Two fixed windows of the address space skip the table and lose their top three bits. A global enable can switch translation off altogether, and then every address is just cut to 29 bits.

Each accepted request gives one response one clock later. The response carries the physical address, a success flag and a 12-bit fault code. The code tells apart a miss, more than one matching entry, a rights violation, and a write to a page that has not been marked dirty. A fault also stores the offending virtual address in a register that stays readable until the next fault. Software fills the table through a load port. Each load writes the slot selected by a replacement counter, and every translated lookup moves that counter on. The counter wraps at a bound that software programs, or at the last slot index.

Top module: `xlat_tlb`

## Requirements
- R1: A privileged request whose address lies in 0x80000000..0xBFFFFFFF or 0xE0000000..0xFFFFFFFF succeeds with physical address equal to the virtual address bits 28:0. This holds whatever the enable bit and the table contents are.
- R2: An unprivileged request in those same windows succeeds only for addresses from 0xE0000000 to 0xE4000000 inclusive. Any other address there faults as a miss (code 0x040 on read, 0x060 on write).
- R3: With `xlat_en` low, a request outside the R1 windows succeeds in either mode with physical address equal to the virtual address bits 28:0.
- R4: The size field of an entry selects the page size: 00 = 1 KB, 01 = 4 KB, 10 = 64 KB, 11 = 1 MB. Virtual and physical page numbers are kept in 1 KB units (address bits 31:10 and 28:10). Their low bits inside the page are ignored when matching and replaced by the virtual address bits when forming the physical address.
- R5: An entry takes part in a match only if its valid bit is set. When `single_vm` and `req_priv` are both low, it must also have an address-space ID equal to `cur_asid` or its shared bit set. Otherwise the ID is ignored.
- R6: A translated request that matches no entry faults as a miss: 0x040 on read, 0x060 on write.
- R7: A translated request that matches two or more entries faults with code 0x140.
- R8: Protection field 00 allows only privileged reads. 01 allows privileged reads and writes. 10 allows reads in both modes. 11 allows everything. A refused read gives 0x0A0 and a refused write gives 0x0C0.
- R9: A write that passes R8 but hits an entry whose dirty bit is clear faults with 0x080. A write to a dirty entry succeeds.
- R10: The replacement counter resets to 0. It advances by one on every request that consults the table (`xlat_en` high and outside the R1 windows). It becomes 0 instead whenever the advanced value would equal `repl_bound` or ENTRIES-1. A load writes the slot given by the counter's current value.
- R11: `rsp_valid` rises exactly one cycle after `req_valid`. On success `rsp_ok` is 1 and `rsp_fault` is 0. On a fault `rsp_ok` is 0, `rsp_paddr` is 0, and `fault_vaddr` takes the request address, which it keeps until the next fault. It resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_priv | input | 1 | 1 = privileged mode |
| cur_asid | input | 8 | Current address-space ID |
| xlat_en | input | 1 | Translation enable |
| single_vm | input | 1 | Single virtual space: ignore address-space IDs |
| repl_bound | input | 6 | Programmable wrap value of the replacement counter |
| ld_en | input | 1 | Write one entry at the counter slot |
| ld_vpn | input | 22 | Virtual page number (address bits 31:10) |
| ld_ppn | input | 19 | Physical page number (address bits 28:10) |
| ld_asid | input | 8 | Entry address-space ID |
| ld_size | input | 2 | Page size code |
| ld_prot | input | 2 | Protection code |
| ld_valid | input | 1 | Entry valid |
| ld_shared | input | 1 | Entry shared across IDs |
| ld_dirty | input | 1 | Entry dirty |
| rsp_valid | output | 1 | Response strobe |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_paddr | output | 29 | Physical address, 0 on fault |
| rsp_fault | output | 12 | Fault code, 0 on success |
| fault_vaddr | output | 32 | Address of the latest faulting request |
| repl_ptr | output | 6 | Replacement counter |

## Verification
The bench builds the block with its defaults: ENTRIES = 8 and a 6-bit counter. Eight slots let a run hold a 1 KB, a 4 KB, a 64 KB and a 1 MB entry at the same time, next to an invalid entry and a deliberately overlapping pair. The counter reaches the last-index wrap after seven table lookups, so that wrap is exercised several times. A later phase sets `repl_bound` to 5 so the programmable wrap fires before the last index does. Stored page numbers with nonzero low bits confirm that those bits are masked, both when matching and when forming the physical address.

// File: rtl/xlat_pkg.sv
// xlat_pkg: shared widths, entry layout, fault codes and the page-size
// mask helper for the translation buffer. Assumes 32-bit virtual and
// 29-bit physical addresses with 1 KB page-number granularity.
package xlat_pkg;

    localparam int VA_W     = 32;
    localparam int PA_W     = 29;
    localparam int PG_SHIFT = 10;
    localparam int VPN_W    = VA_W - PG_SHIFT;
    localparam int PPN_W    = PA_W - PG_SHIFT;
    localparam int ASID_W   = 8;
    localparam int CODE_W   = 12;

    typedef enum logic [1:0] {
        PG_1K  = 2'b00,
        PG_4K  = 2'b01,
        PG_64K = 2'b10,
        PG_1M  = 2'b11
    } pg_size_e;

    typedef struct packed {
        logic              valid;
        logic              shared;
        logic              dirty;
        logic [1:0]        prot;
        logic [1:0]        size;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
    } tlb_ent_t;

    localparam logic [CODE_W-1:0] FC_NONE    = 12'h000;
    localparam logic [CODE_W-1:0] FC_MISS_RD = 12'h040;
    localparam logic [CODE_W-1:0] FC_MISS_WR = 12'h060;
    localparam logic [CODE_W-1:0] FC_INIT_WR = 12'h080;
    localparam logic [CODE_W-1:0] FC_PROT_RD = 12'h0A0;
    localparam logic [CODE_W-1:0] FC_PROT_WR = 12'h0C0;
    localparam logic [CODE_W-1:0] FC_MULTI   = 12'h140;

    // Page-number bits that take part in a compare for a given size code.
    function automatic logic [VPN_W-1:0] keep_mask(input logic [1:0] sz);
        logic [VPN_W-1:0] ones;
        ones = '1;
        case (pg_size_e'(sz))
            PG_1K:   keep_mask = ones;
            PG_4K:   keep_mask = ones << 2;
            PG_64K:  keep_mask = ones << 6;
            default: keep_mask = ones << 10;
        endcase
    endfunction

endpackage

// File: rtl/xlat_store.sv
// xlat_store: register array of translation entries with a single write
// port. Reset clears every entry (valid low). Assumes wr_idx < ENTRIES.
module xlat_store
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_ent_t         wr_ent,
    output tlb_ent_t         ents [ENTRIES]
);

    tlb_ent_t ents_q [ENTRIES];

    // Clear on reset, otherwise write one slot on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ents_q[i] <= '0;
        end else if (wr_en) begin
            ents_q[wr_idx] <= wr_ent;
        end
    end

    assign ents = ents_q;

    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ents_q[$past(wr_idx)] == $past(wr_ent)); // R10

endmodule

// File: rtl/xlat_match.sv
// xlat_match: parallel compare of one virtual page number against every
// entry, honouring page size, valid bit, address-space ID and shared bit.
// Reports any hit, a multiple hit, and the fields of the hit entry (the
// fields are an OR of all hitting entries and only meaningful on one hit).
module xlat_match
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tlb_ent_t          ents [ENTRIES],
    input  logic [VPN_W-1:0]  vpn_in,
    input  logic [ASID_W-1:0] asid_in,
    input  logic              use_asid,
    output logic              hit_any,
    output logic              hit_multi,
    output logic [1:0]        hit_prot,
    output logic              hit_dirty,
    output logic [1:0]        hit_size,
    output logic [PPN_W-1:0]  hit_ppn
);

    localparam int CNT_W = $clog2(ENTRIES + 1);

    logic [ENTRIES-1:0] hits;
    logic [CNT_W-1:0]   n_hits;
    tlb_ent_t           merged;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [VPN_W-1:0] m;
        logic             id_ok;
        logic             pg_ok;
        // Per-entry match: size-masked page compare plus ID qualification.
        always_comb begin
            m     = keep_mask(ents[g].size);
            id_ok = !use_asid || ents[g].shared || (ents[g].asid == asid_in);
            pg_ok = ((ents[g].vpn ^ vpn_in) & m) == '0;
            hits[g] = ents[g].valid && id_ok && pg_ok;
        end
    end

    // Count hits and merge the fields of the hitting entries.
    always_comb begin
        n_hits = '0;
        merged = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            n_hits = n_hits + CNT_W'(hits[i]);
            if (hits[i]) merged = tlb_ent_t'(merged | ents[i]);
        end
    end

    assign hit_any   = |hits;
    assign hit_multi = n_hits > CNT_W'(1);
    assign hit_prot  = merged.prot;
    assign hit_dirty = merged.dirty;
    assign hit_size  = merged.size;
    assign hit_ppn   = merged.ppn;

    AST_SINGLE_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_any && !hit_multi) |-> $onehot(hits)); // R7

endmodule

// File: rtl/xlat_rights.sv
// xlat_rights: decodes the 2-bit protection code against mode and access
// direction and yields a fault code; a permitted write to a clean page
// gets the first-write code. Purely combinational; clock is for checks.
module xlat_rights
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        prot,
    input  logic              dirty,
    input  logic              is_write,
    input  logic              priv,
    output logic [CODE_W-1:0] code
);

    logic rd_ok;
    logic wr_ok;

    // Rights table: bit 1 opens user access, bit 0 opens writes.
    always_comb begin
        rd_ok = prot[1] || priv;
        wr_ok = prot[0] && (prot[1] || priv);
        if (is_write) begin
            if (!wr_ok)      code = FC_PROT_WR;
            else if (!dirty) code = FC_INIT_WR;
            else             code = FC_NONE;
        end else begin
            code = rd_ok ? FC_NONE : FC_PROT_RD;
        end
    end

    AST_USER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!priv && !prot[1]) |-> (code == FC_PROT_RD || code == FC_PROT_WR)); // R8
    AST_FIRST_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (code == FC_INIT_WR) |-> (is_write && !dirty)); // R9

endmodule

// File: rtl/xlat_repl.sv
// xlat_repl: replacement counter. Advances on each step and returns to 0
// when the advanced value equals the programmed bound or the last slot.
// Assumes 2 <= ENTRIES <= 2**CTR_W.
module xlat_repl #(
    parameter int ENTRIES = 8,
    parameter int CTR_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [CTR_W-1:0] bound,
    output logic [CTR_W-1:0] ctr
);

    localparam logic [CTR_W-1:0] LAST = CTR_W'(ENTRIES - 1);

    logic [CTR_W-1:0] ctr_q;
    logic [CTR_W-1:0] inc;

    // Advanced value with both wrap conditions.
    always_comb begin
        inc = ctr_q + CTR_W'(1);
        if (inc == bound || inc == LAST) inc = '0;
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)    ctr_q <= '0;
        else if (step) ctr_q <= inc;
    end

    assign ctr = ctr_q;

    AST_CTR_BELOW_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_q < LAST); // R10
    AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(ctr_q)); // R10
    AST_CTR_WRAP_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ctr_q == LAST - CTR_W'(1)) |=> ctr_q == '0); // R10

endmodule

// File: rtl/xlat_tlb.sv
// xlat_tlb: top of the translation buffer. Decodes the untranslated
// windows, chooses between pass-through and table lookup, forms the
// physical address and fault code, and registers the result one cycle
// after the request. Captures the virtual address of every fault.
// Assumes one request per cycle at most and 2 <= ENTRIES <= 2**CTR_W.
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int CTR_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic              req_priv,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              xlat_en,
    input  logic              single_vm,
    input  logic [CTR_W-1:0]  repl_bound,
    input  logic              ld_en,
    input  logic [VPN_W-1:0]  ld_vpn,
    input  logic [PPN_W-1:0]  ld_ppn,
    input  logic [ASID_W-1:0] ld_asid,
    input  logic [1:0]        ld_size,
    input  logic [1:0]        ld_prot,
    input  logic              ld_valid,
    input  logic              ld_shared,
    input  logic              ld_dirty,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [CODE_W-1:0] rsp_fault,
    output logic [VA_W-1:0]   fault_vaddr,
    output logic [CTR_W-1:0]  repl_ptr
);

    localparam int IDX_W = $clog2(ENTRIES);

    tlb_ent_t          ents [ENTRIES];
    tlb_ent_t          ld_ent;
    logic              in_bypass;
    logic              user_window;
    logic              use_asid;
    logic              table_step;
    logic              hit_any;
    logic              hit_multi;
    logic [1:0]        hit_prot;
    logic              hit_dirty;
    logic [1:0]        hit_size;
    logic [PPN_W-1:0]  hit_ppn;
    logic [CODE_W-1:0] rights_code;
    logic [CTR_W-1:0]  ctr;
    logic [PPN_W-1:0]  pmask;
    logic [PA_W-1:0]   pa_flat;
    logic [PA_W-1:0]   pa_mapped;
    logic [CODE_W-1:0] code_d;
    logic [PA_W-1:0]   pa_d;

    // Window decode and lookup qualifiers.
    always_comb begin
        in_bypass   = (req_vaddr[31:30] == 2'b10) || (req_vaddr[31:29] == 3'b111);
        user_window = (req_vaddr >= 32'hE000_0000) && (req_vaddr <= 32'hE400_0000);
        use_asid    = !single_vm && !req_priv;
        table_step  = req_valid && xlat_en && !in_bypass;
    end

    // Pack the load port into an entry.
    always_comb begin
        ld_ent.valid  = ld_valid;
        ld_ent.shared = ld_shared;
        ld_ent.dirty  = ld_dirty;
        ld_ent.prot   = ld_prot;
        ld_ent.size   = ld_size;
        ld_ent.asid   = ld_asid;
        ld_ent.vpn    = ld_vpn;
        ld_ent.ppn    = ld_ppn;
    end

    xlat_repl #(.ENTRIES(ENTRIES), .CTR_W(CTR_W)) u_repl (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (table_step),
        .bound (repl_bound),
        .ctr   (ctr)
    );

    xlat_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ld_en),
        .wr_idx (ctr[IDX_W-1:0]),
        .wr_ent (ld_ent),
        .ents   (ents)
    );

    xlat_match #(.ENTRIES(ENTRIES)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .ents      (ents),
        .vpn_in    (req_vaddr[VA_W-1:PG_SHIFT]),
        .asid_in   (cur_asid),
        .use_asid  (use_asid),
        .hit_any   (hit_any),
        .hit_multi (hit_multi),
        .hit_prot  (hit_prot),
        .hit_dirty (hit_dirty),
        .hit_size  (hit_size),
        .hit_ppn   (hit_ppn)
    );

    xlat_rights u_rights (
        .clk      (clk),
        .rst_n    (rst_n),
        .prot     (hit_prot),
        .dirty    (hit_dirty),
        .is_write (req_write),
        .priv     (req_priv),
        .code     (rights_code)
    );

    // Physical address forms: flat cut to 29 bits, and page-mapped.
    always_comb begin
        pmask     = keep_mask(hit_size)[PPN_W-1:0];
        pa_flat   = req_vaddr[PA_W-1:0];
        pa_mapped = {(hit_ppn & pmask) | (req_vaddr[PA_W-1:PG_SHIFT] & ~pmask),
                     req_vaddr[PG_SHIFT-1:0]};
    end

    // Result selection in priority order: window, disable, table.
    always_comb begin
        pa_d = pa_flat;
        if (in_bypass) begin
            code_d = (req_priv || user_window) ? FC_NONE
                   : (req_write ? FC_MISS_WR : FC_MISS_RD);
        end else if (!xlat_en) begin
            code_d = FC_NONE;
        end else if (hit_multi) begin
            code_d = FC_MULTI;
        end else if (!hit_any) begin
            code_d = req_write ? FC_MISS_WR : FC_MISS_RD;
        end else begin
            code_d = rights_code;
            pa_d   = pa_mapped;
        end
    end

    // Response and fault-address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_ok      <= 1'b0;
            rsp_paddr   <= '0;
            rsp_fault   <= '0;
            fault_vaddr <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_ok    <= (code_d == FC_NONE);
                rsp_fault <= code_d;
                rsp_paddr <= (code_d == FC_NONE) ? pa_d : '0;
                if (code_d != FC_NONE) fault_vaddr <= req_vaddr;
            end
        end
    end

    assign repl_ptr = ctr;

    AST_PRIV_WINDOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv && (req_vaddr[31:30] == 2'b10 || req_vaddr[31:29] == 3'b111))
        |=> (rsp_ok && rsp_paddr == $past(req_vaddr[PA_W-1:0]))); // R1
    AST_USER_LOW_WINDOW_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_priv && req_vaddr[31:30] == 2'b10)
        |=> (!rsp_ok && (rsp_fault == FC_MISS_RD || rsp_fault == FC_MISS_WR))); // R2
    AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !xlat_en && req_vaddr < 32'h8000_0000)
        |=> (rsp_ok && rsp_paddr == $past(req_vaddr[PA_W-1:0]))); // R3
    AST_OK_MEANS_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_ok == (rsp_fault == FC_NONE))); // R11
    AST_FAULT_ADDR_CAUGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> (fault_vaddr == $past(req_vaddr))); // R11
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R11

endmodule

// File: tb/test_xlat_tlb.sv
// Scoreboard bench: lookup() pushes the expected response, a monitor at
// the falling edge pops and compares each response.
module test_xlat_tlb;

    localparam int ENT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_priv = 1'b0;
    logic [7:0]  cur_asid = '0;
    logic        xlat_en = 1'b0;
    logic        single_vm = 1'b0;
    logic [5:0]  repl_bound = 6'h3F;
    logic        ld_en = 1'b0;
    logic [21:0] ld_vpn = '0;
    logic [18:0] ld_ppn = '0;
    logic [7:0]  ld_asid = '0;
    logic [1:0]  ld_size = '0;
    logic [1:0]  ld_prot = '0;
    logic        ld_valid = 1'b0;
    logic        ld_shared = 1'b0;
    logic        ld_dirty = 1'b0;
    logic        rsp_valid;
    logic        rsp_ok;
    logic [28:0] rsp_paddr;
    logic [11:0] rsp_fault;
    logic [31:0] fault_vaddr;
    logic [5:0]  repl_ptr;

    xlat_tlb #(.ENTRIES(ENT), .CTR_W(6)) i_xlat_tlb (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_priv(req_priv), .cur_asid(cur_asid),
        .xlat_en(xlat_en), .single_vm(single_vm), .repl_bound(repl_bound),
        .ld_en(ld_en), .ld_vpn(ld_vpn), .ld_ppn(ld_ppn), .ld_asid(ld_asid),
        .ld_size(ld_size), .ld_prot(ld_prot), .ld_valid(ld_valid),
        .ld_shared(ld_shared), .ld_dirty(ld_dirty), .rsp_valid(rsp_valid),
        .rsp_ok(rsp_ok), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .fault_vaddr(fault_vaddr), .repl_ptr(repl_ptr)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic        ok;
        logic [11:0] code;
        logic [28:0] pa;
        logic [31:0] va;
        logic [5:0]  ctr;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    logic [5:0]  exp_ctr = '0;
    logic [31:0] exp_fva = '0;
    bit          done = 1'b0;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Driver: one lookup in the next cycle, expected result queued.
    task automatic lookup(input logic [31:0] va, input logic wr, input logic pv,
                          input logic ok, input logic [11:0] code,
                          input logic [28:0] pa, input string tag);
        exp_t e;
        logic [5:0] nx;
        logic byp;
        @(negedge clk);
        ld_en     = 1'b0;
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = wr;
        req_priv  = pv;
        byp = (va[31:30] == 2'b10) || (va[31:29] == 3'b111);
        if (xlat_en && !byp) begin
            nx = exp_ctr + 6'd1;
            if (nx == repl_bound || nx == 6'(ENT - 1)) nx = 6'd0;
            exp_ctr = nx;
        end
        e.ok = ok; e.code = code; e.pa = ok ? pa : 29'h0;
        e.va = va; e.ctr = exp_ctr; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic load(input logic [31:0] va, input logic [28:0] pa,
                        input logic [7:0] asid, input logic [1:0] sz,
                        input logic [1:0] pr, input logic v, input logic sh,
                        input logic d);
        @(negedge clk);
        req_valid = 1'b0;
        ld_en     = 1'b1;
        ld_vpn    = va[31:10];
        ld_ppn    = pa[28:10];
        ld_asid   = asid;
        ld_size   = sz;
        ld_prot   = pr;
        ld_valid  = v;
        ld_shared = sh;
        ld_dirty  = d;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        ld_en     = 1'b0;
    endtask

    // Monitor: compare every response with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_cmp++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL R11 unexpected response: got rsp_valid=1 expected 0");
            end else begin
                exp_t e;
                e = q.pop_front();
                if (!e.ok) exp_fva = e.va;
                if (rsp_ok !== e.ok || rsp_fault !== e.code || rsp_paddr !== e.pa ||
                    fault_vaddr !== exp_fva || repl_ptr !== e.ctr) begin
                    n_bad++;
                    $display("FAIL %s: got ok=%0b code=%h pa=%h fva=%h ptr=%0d expected ok=%0b code=%h pa=%h fva=%h ptr=%0d",
                             e.tag, rsp_ok, rsp_fault, rsp_paddr, fault_vaddr, repl_ptr,
                             e.ok, e.code, e.pa, exp_fva, e.ctr);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no end of run expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R10, R11)
        n_cmp++;
        if (rsp_valid !== 1'b0 || repl_ptr !== 6'd0 || fault_vaddr !== 32'h0) begin
            n_bad++;
            $display("FAIL R10/R11 reset: got valid=%0b ptr=%0d fva=%h expected 0 0 0",
                     rsp_valid, repl_ptr, fault_vaddr);
        end

        xlat_en  = 1'b1;
        cur_asid = 8'h05;
        // R1 privileged windows
        lookup(32'h8123_4567, 1'b0, 1'b1, 1'b1, 12'h000, 29'h0123_4567, "R1 priv low window read");
        lookup(32'hFFFF_FFF0, 1'b1, 1'b1, 1'b1, 12'h000, 29'h1FFF_FFF0, "R1 priv high window write");
        // R2 user windows
        lookup(32'hE000_0010, 1'b0, 1'b0, 1'b1, 12'h000, 29'h0000_0010, "R2 user window start");
        lookup(32'hE400_0000, 1'b0, 1'b0, 1'b1, 12'h000, 29'h0400_0000, "R2 user window end");
        lookup(32'hE400_0004, 1'b0, 1'b0, 1'b0, 12'h040, 29'h0, "R2 user past window read");
        lookup(32'h9000_0000, 1'b1, 1'b0, 1'b0, 12'h060, 29'h0, "R2 user low window write");
        // R3 translation off
        idle(); xlat_en = 1'b0;
        lookup(32'h1234_5678, 1'b1, 1'b0, 1'b1, 12'h000, 29'h1234_5678, "R3 disabled user write");
        lookup(32'h7FFF_FFFF, 1'b0, 1'b1, 1'b1, 12'h000, 29'h1FFF_FFFF, "R3 disabled priv read");
        idle(); xlat_en = 1'b1;

        // A: 4 KB, rw, dirty, id 5 -> slot 0
        load(32'h0040_0000, 29'h0123_4000, 8'h05, 2'b01, 2'b11, 1'b1, 1'b0, 1'b1);
        lookup(32'h0040_0ABC, 1'b0, 1'b0, 1'b1, 12'h000, 29'h0123_4ABC, "R4 4KB hit");
        idle(); cur_asid = 8'h06;
        lookup(32'h0040_0ABC, 1'b0, 1'b0, 1'b0, 12'h040, 29'h0, "R5 id mismatch miss");
        lookup(32'h0040_0ABC, 1'b0, 1'b1, 1'b1, 12'h000, 29'h0123_4ABC, "R5 priv ignores id");
        idle(); single_vm = 1'b1;
        lookup(32'h0040_0ABC, 1'b0, 1'b0, 1'b1, 12'h000, 29'h0123_4ABC, "R5 single space ignores id");
        idle(); single_vm = 1'b0; cur_asid = 8'h05;

        // B: 64 KB, read-only, clean, shared, id 0x22 -> slot 4
        load(32'h1230_0000, 29'h0567_0000, 8'h22, 2'b10, 2'b10, 1'b1, 1'b1, 1'b0);
        lookup(32'h1230_F00D, 1'b0, 1'b0, 1'b1, 12'h000, 29'h0567_F00D, "R4 R5 64KB shared hit");
        lookup(32'h1230_0010, 1'b1, 1'b0, 1'b0, 12'h0C0, 29'h0, "R8 read-only write");
        lookup(32'h1231_0000, 1'b0, 1'b0, 1'b0, 12'h040, 29'h0, "R4 R6 past 64KB page, R10 last wrap");

        // C: 1 MB, priv read-only, unaligned stored numbers -> slot 0
        load(32'h2003_0000, 29'h1F45_6000, 8'h05, 2'b11, 2'b00, 1'b1, 1'b0, 1'b1);
        lookup(32'h200A_BCDE, 1'b0, 1'b1, 1'b1, 12'h000, 29'h1F4A_BCDE, "R4 1MB masked hit");
        lookup(32'h2000_0000, 1'b1, 1'b1, 1'b0, 12'h0C0, 29'h0, "R8 prot00 priv write");
        lookup(32'h2000_0004, 1'b0, 1'b0, 1'b0, 12'h0A0, 29'h0, "R8 prot00 user read");

        // D: 1 KB, priv rw, clean -> slot 3
        load(32'h0000_4400, 29'h0000_8800, 8'h05, 2'b00, 2'b01, 1'b1, 1'b0, 1'b0);
        lookup(32'h0000_47FF, 1'b0, 1'b1, 1'b1, 12'h000, 29'h0000_8BFF, "R4 1KB hit");
        lookup(32'h0000_4400, 1'b1, 1'b1, 1'b0, 12'h080, 29'h0, "R9 clean page write");
        lookup(32'h0000_4400, 1'b1, 1'b0, 1'b0, 12'h0C0, 29'h0, "R8 R9 prot01 user write");

        // E: 4 KB overlapping D, rw, dirty -> slot 6
        load(32'h0000_4000, 29'h0003_0000, 8'h05, 2'b01, 2'b11, 1'b1, 1'b0, 1'b1);
        lookup(32'h0000_4410, 1'b0, 1'b1, 1'b0, 12'h140, 29'h0, "R7 multiple hit");
        lookup(32'h0000_4C00, 1'b1, 1'b1, 1'b1, 12'h000, 29'h0003_0C00, "R9 dirty page write");

        // F: invalid entry -> slot 1
        load(32'h0050_0000, 29'h0006_0000, 8'h05, 2'b01, 2'b11, 1'b0, 1'b0, 1'b1);
        lookup(32'h0050_0000, 1'b0, 1'b1, 1'b0, 12'h040, 29'h0, "R5 invalid entry miss");
        lookup(32'h0060_0000, 1'b1, 1'b1, 1'b0, 12'h060, 29'h0, "R6 write miss");

        // R10 programmable bound
        idle(); repl_bound = 6'd5;
        lookup(32'h0000_4C00, 1'b0, 1'b1, 1'b1, 12'h000, 29'h0003_0C00, "R10 step below bound");
        lookup(32'h200A_BCDE, 1'b0, 1'b1, 1'b1, 12'h000, 29'h1F4A_BCDE, "R10 bound wrap");
        lookup(32'h1230_0000, 1'b0, 1'b1, 1'b1, 12'h000, 29'h0567_0000, "R8 R11 read-only priv read");

        idle();
        repeat (3) idle();
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R11 missing responses: got %0d pending expected 0", q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule